// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface Decoder

This block is the host-side front end of a peripheral controller. It compares an incoming I/O address against a programmable base, waits for a read or write strobe before it starts a register cycle, and drives an active-low 16-bit acknowledge as soon as the address decodes. It also works out which of three host bus styles is in use and keeps that result up to date for the rest of the controller.

The block powers up in the plain local-bus style. A mode pin switches it to a PC-card style, in which the host has already decoded the slot, so the upper address bits play no part. In this style a configuration bit can also open a flash write enable that follows the memory write strobe. If both I/O strobes are seen active together, the block moves to a 68000-style mode. That mode first waits for a confirming write and stays locked until a hard reset. The strobes are synchronized to the block clock before any of this logic sees them.

Top module: `hostbus_decode`

## Requirements
- R1: After reset, `mode` is 2'b00 (local bus) and `cyc_rd`, `cyc_wr`, `rd_ones` and `reg_sel` are low.
- R2: In local-bus mode (`mode`=00), when `addr[15:4]` equals `io_base` and `aen` is low, activating `ior_n` (or `iow_n`) alone gives a one-clock `cyc_rd` (or `cyc_wr`) pulse. The pulse appears on the third rising clock edge after the strobe falls. On that same edge `reg_ofs` holds `addr[3:0]` and `reg_sel` is high while the strobe stays active.
- R3: No cycle pulse is produced without a strobe, when `addr[15:4]` differs from `io_base`, or when `aen` is high in local-bus mode. At most one of `cyc_rd`, `cyc_wr` and `rd_ones` is high in any cycle.
- R4: `ack16_n` is low whenever the address decodes and either `bus16` is 1 or `mode[1]` is 1. It is high otherwise. It follows the address combinationally, with no strobe needed.
- R5: With `card_sel` at 1, `mode` becomes 2'b01 (PC card) one clock later. In that mode `addr[15:4]` and `aen` are ignored and every strobe starts a cycle. When `card_sel` returns to 0, `mode` goes back to 00.
- R6: `flash_we_n` is low only when `mode` is 01, `mwe_n` is low and `cfg_flash_en` is 1. It is high in every other mode.
- R7: From local-bus mode only, both synchronized strobes active on two consecutive clocks moves `mode` to 2'b10 (68000, unconfirmed). An overlap lasting a single clock does not, and an overlap in PC-card mode never does.
- R8: In mode 10, a decoded read produces a one-clock `rd_ones` pulse (the read data is all ones) and no `cyc_rd`. A decoded write produces `cyc_wr` and moves `mode` to 2'b11 (68000, confirmed) on the same edge.
- R9: Once `mode[1]` is 1, only `rst_n` clears it. `card_sel` and further strobes leave it set.
- R10: In modes 10 and 11, decoding uses `io_base` and requires `aen` low, as in local-bus mode. The acknowledge is given even when `bus16` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hard reset |
| addr | input | 16 | Host I/O address |
| aen | input | 1 | Address enable, high blocks local decoding |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| mwe_n | input | 1 | Active-low memory write strobe |
| card_sel | input | 1 | High selects PC-card operation |
| cfg_flash_en | input | 1 | Configuration bit enabling flash writes |
| bus16 | input | 1 | High when the adapter runs 16 bits wide |
| io_base | input | 12 | Programmed I/O base, compared with addr[15:4] |
| reg_sel | output | 1 | High while a decoded cycle is active |
| reg_ofs | output | 4 | Register offset captured at cycle start |
| cyc_rd | output | 1 | One-clock read cycle start |
| cyc_wr | output | 1 | One-clock write cycle start |
| rd_ones | output | 1 | One-clock pulse: unconfirmed read, data all ones |
| ack16_n | output | 1 | Active-low 16-bit acknowledge |
| flash_we_n | output | 1 | Active-low flash write enable |
| mode | output | 2 | 00 local, 01 PC card, 10 68000 unconfirmed, 11 68000 confirmed |

## Verification
The bench holds both strobes together for only one clock to check that the 68000 mode does not latch on a brief overlap. A detector without the two-clock qualification would lock up after such a glitch. It reads in the unconfirmed 68000 mode and checks that the read is answered with ones and never reaches the registers. It also checks that a PC-card selection made after locking cannot pull the block out of the 68000 mode. Other cases cover a wrong address, a high address enable, flash enable outside PC-card mode, and the acknowledge with `bus16` low in 68000 mode. A design that compared upper address bits in PC-card mode, or that did not force the acknowledge in 68000 mode, fails these checks.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
   typedef enum logic [1:0] {
      HB_LOCAL    = 2'b00,
      HB_CARD     = 2'b01,
      HB_M68_PEND = 2'b10,
      HB_M68      = 2'b11
   } hb_mode_e;
endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer, one flop chain per bit, reset to inactive (0).
module hb_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_addr_match.sv
// Combinational address decode and 16-bit acknowledge.
module hb_addr_match
   import hostbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 4
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    aen,
   input  logic [ADDR_W-OFS_W-1:0] io_base,
   input  hb_mode_e                mode,
   input  logic                    bus16,
   output logic                    hit,
   output logic                    ack16_n
);
   localparam int BASE_W = ADDR_W - OFS_W;

   if (BASE_W < 1) begin : g_bad_width
      $error("hb_addr_match: ADDR_W must exceed OFS_W");
   end

   logic base_eq;
   logic wide;

   assign base_eq = (addr[ADDR_W-1:OFS_W] == io_base) && !aen;

   always_comb begin
      unique case (mode)
         HB_CARD: hit = 1'b1;
         default: hit = base_eq;
      endcase
   end

   // 68000 style is 16 bits only
   assign wide    = bus16 || (mode == HB_M68_PEND) || (mode == HB_M68);
   assign ack16_n = !(hit && wide);
endmodule

// File: rtl/hb_mode_fsm.sv
// Tracks the active host bus style; the 68000 style is sticky until reset.
module hb_mode_fsm
   import hostbus_pkg::*;
#(
   parameter int BOTH_CYCLES = 2,
   parameter bit ENABLE_M68  = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rd_s,
   input  logic     wr_s,
   input  logic     card_sel,
   input  logic     wr_go,
   output hb_mode_e mode
);
   if (BOTH_CYCLES < 1) begin : g_bad_cycles
      $error("hb_mode_fsm: BOTH_CYCLES must be at least 1");
   end

   localparam int CNT_W = (BOTH_CYCLES < 2) ? 1 : $clog2(BOTH_CYCLES);

   logic     detect;
   hb_mode_e mode_nx;

   if (ENABLE_M68) begin : g_m68
      logic [CNT_W-1:0] both_cnt;
      logic             both;

      assign both = rd_s && wr_s && (mode == HB_LOCAL) && !card_sel;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            both_cnt <= '0;
         end else if (both) begin
            if (both_cnt != CNT_W'(BOTH_CYCLES-1)) both_cnt <= both_cnt + 1'b1;
         end else begin
            both_cnt <= '0;
         end
      end

      assign detect = both && (both_cnt == CNT_W'(BOTH_CYCLES-1));
   end else begin : g_no_m68
      assign detect = 1'b0;
   end

   always_comb begin
      mode_nx = mode;
      unique case (mode)
         HB_LOCAL: begin
            if (detect)        mode_nx = HB_M68_PEND;
            else if (card_sel) mode_nx = HB_CARD;
         end
         HB_CARD: begin
            if (!card_sel) mode_nx = HB_LOCAL;
         end
         HB_M68_PEND: begin
            if (wr_go) mode_nx = HB_M68;
         end
         HB_M68: mode_nx = HB_M68;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= HB_LOCAL;
      else        mode <= mode_nx;
   end
endmodule

// File: rtl/hb_cycle_gen.sv
// Turns synchronized strobes plus a decode hit into cycle start pulses.
module hb_cycle_gen
   import hostbus_pkg::*;
#(
   parameter int OFS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_s,
   input  logic             wr_s,
   input  logic             hit,
   input  hb_mode_e         mode,
   input  logic [OFS_W-1:0] ofs_in,
   output logic             wr_go,
   output logic             cyc_rd,
   output logic             cyc_wr,
   output logic             rd_ones,
   output logic             reg_sel,
   output logic [OFS_W-1:0] reg_ofs
);
   logic rd_d, wr_d;
   logic rd_go;
   logic pend;
   logic sel_nx;

   assign pend   = (mode == HB_M68_PEND);
   assign rd_go  = rd_s && !rd_d && !wr_s && hit;
   assign wr_go  = wr_s && !wr_d && !rd_s && hit;
   assign sel_nx = hit && (rd_s ^ wr_s) && !(rd_s && pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d    <= 1'b0;
         wr_d    <= 1'b0;
         cyc_rd  <= 1'b0;
         cyc_wr  <= 1'b0;
         rd_ones <= 1'b0;
         reg_sel <= 1'b0;
         reg_ofs <= '0;
      end else begin
         rd_d    <= rd_s;
         wr_d    <= wr_s;
         cyc_rd  <= rd_go && !pend;
         rd_ones <= rd_go && pend;
         cyc_wr  <= wr_go;
         reg_sel <= sel_nx;
         if (rd_go || wr_go) reg_ofs <= ofs_in;
      end
   end
endmodule

// File: rtl/hostbus_decode.sv
module hostbus_decode
   import hostbus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int OFS_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int BOTH_CYCLES = 2,
   parameter bit ENABLE_M68  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    aen,
   input  logic                    ior_n,
   input  logic                    iow_n,
   input  logic                    mwe_n,
   input  logic                    card_sel,
   input  logic                    cfg_flash_en,
   input  logic                    bus16,
   input  logic [ADDR_W-OFS_W-1:0] io_base,
   output logic                    reg_sel,
   output logic [OFS_W-1:0]        reg_ofs,
   output logic                    cyc_rd,
   output logic                    cyc_wr,
   output logic                    rd_ones,
   output logic                    ack16_n,
   output logic                    flash_we_n,
   output logic [1:0]              mode
);
   logic [1:0] strb_s;
   logic       hit;
   logic       wr_go;
   hb_mode_e   mode_q;

   hb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({!ior_n, !iow_n}),
      .q     (strb_s)
   );

   hb_addr_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
      .addr    (addr),
      .aen     (aen),
      .io_base (io_base),
      .mode    (mode_q),
      .bus16   (bus16),
      .hit     (hit),
      .ack16_n (ack16_n)
   );

   hb_mode_fsm #(.BOTH_CYCLES(BOTH_CYCLES), .ENABLE_M68(ENABLE_M68)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_s     (strb_s[1]),
      .wr_s     (strb_s[0]),
      .card_sel (card_sel),
      .wr_go    (wr_go),
      .mode     (mode_q)
   );

   hb_cycle_gen #(.OFS_W(OFS_W)) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_s    (strb_s[1]),
      .wr_s    (strb_s[0]),
      .hit     (hit),
      .mode    (mode_q),
      .ofs_in  (addr[OFS_W-1:0]),
      .wr_go   (wr_go),
      .cyc_rd  (cyc_rd),
      .cyc_wr  (cyc_wr),
      .rd_ones (rd_ones),
      .reg_sel (reg_sel),
      .reg_ofs (reg_ofs)
   );

   assign flash_we_n = !((mode_q == HB_CARD) && !mwe_n && cfg_flash_en);
   assign mode       = mode_q;
endmodule

// File: rtl/hostbus_decode_chk.sv
module hostbus_decode_chk #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       addr,
   input logic                    aen,
   input logic                    mwe_n,
   input logic                    cfg_flash_en,
   input logic [ADDR_W-OFS_W-1:0] io_base,
   input logic                    cyc_rd,
   input logic                    cyc_wr,
   input logic                    rd_ones,
   input logic                    ack16_n,
   input logic                    flash_we_n,
   input logic [1:0]              mode
);
   assert_m68_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |=> mode[1]);

   assert_pend_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_rd |-> ($past(mode) != 2'b10));

   assert_confirm_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode) == 2'b10) && (mode == 2'b11)) |-> cyc_wr);

   assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cyc_rd, cyc_wr, rd_ones}));

   assert_flash_card_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> ((mode == 2'b01) && !mwe_n && cfg_flash_en));

   assert_card_no_m68_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> !mode[1]);

   assert_m68_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && !aen && (addr[ADDR_W-1:OFS_W] == io_base)) |-> !ack16_n);
endmodule

bind hostbus_decode hostbus_decode_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .aen          (aen),
   .mwe_n        (mwe_n),
   .cfg_flash_en (cfg_flash_en),
   .io_base      (io_base),
   .cyc_rd       (cyc_rd),
   .cyc_wr       (cyc_wr),
   .rd_ones      (rd_ones),
   .ack16_n      (ack16_n),
   .flash_we_n   (flash_we_n),
   .mode         (mode)
);

// File: tb/hostbus_decode_bench.sv
`timescale 1ns/1ps
module hostbus_decode_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        aen = 1'b1;
   logic        ior_n = 1'b1, iow_n = 1'b1, mwe_n = 1'b1;
   logic        card_sel = 1'b0, cfg_flash_en = 1'b0, bus16 = 1'b1;
   logic [11:0] io_base = 12'h030;
   logic        reg_sel, cyc_rd, cyc_wr, rd_ones, ack16_n, flash_we_n;
   logic [3:0]  reg_ofs;
   logic [1:0]  mode;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hostbus_decode u_hostbus_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .aen(aen), .ior_n(ior_n),
      .iow_n(iow_n), .mwe_n(mwe_n), .card_sel(card_sel),
      .cfg_flash_en(cfg_flash_en), .bus16(bus16), .io_base(io_base),
      .reg_sel(reg_sel), .reg_ofs(reg_ofs), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr),
      .rd_ones(rd_ones), .ack16_n(ack16_n), .flash_we_n(flash_we_n),
      .mode(mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One strobe cycle; samples on the third rising edge after the strobe falls.
   task automatic do_cycle(input bit is_wr, input logic [15:0] a, input bit aen_v,
                           output logic [4:0] got, output logic [3:0] ofs);
      @(negedge clk);
      addr = a; aen = aen_v;
      if (is_wr) iow_n = 1'b0; else ior_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      got = {reg_sel, cyc_rd, cyc_wr, rd_ones, 1'b0};
      ofs = reg_ofs;
      @(negedge clk);
      ior_n = 1'b1; iow_n = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; card_sel = 1'b0; ior_n = 1'b1; iow_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
   endtask

   task automatic t_reset();
      #1;
      check("R1 mode", mode, 2'b00);
      check("R1 pulses", {cyc_rd, cyc_wr, rd_ones, reg_sel}, 4'b0000);
   endtask

   task automatic t_local();
      logic [4:0] g; logic [3:0] o;
      do_cycle(1'b0, 16'h0305, 1'b0, g, o);
      check("R2 read {sel,rd,wr,ones}", g[4:1], 4'b1100);
      check("R2 read offset", o, 4'h5);
      do_cycle(1'b1, 16'h030A, 1'b0, g, o);
      check("R2 write {sel,rd,wr,ones}", g[4:1], 4'b1010);
      check("R2 write offset", o, 4'hA);
   endtask

   task automatic t_nomatch();
      logic [4:0] g; logic [3:0] o;
      do_cycle(1'b0, 16'h0405, 1'b0, g, o);
      check("R3 wrong base", g[4:1], 4'b0000);
      do_cycle(1'b1, 16'h0305, 1'b1, g, o);
      check("R3 aen high", g[4:1], 4'b0000);
      @(negedge clk); addr = 16'h0307; aen = 1'b0;
      repeat (5) @(posedge clk); #1;
      check("R3 no strobe", {cyc_rd, cyc_wr, reg_sel}, 3'b000);
   endtask

   task automatic t_ack();
      @(negedge clk); addr = 16'h0301; aen = 1'b0; bus16 = 1'b1; #1;
      check("R4 ack match bus16", ack16_n, 1'b0);
      bus16 = 1'b0; #1;
      check("R4 ack 8-bit", ack16_n, 1'b1);
      bus16 = 1'b1; addr = 16'h0501; #1;
      check("R4 ack mismatch", ack16_n, 1'b1);
   endtask

   task automatic t_short_overlap();
      @(negedge clk); aen = 1'b1; ior_n = 1'b0; iow_n = 1'b0;
      @(negedge clk); ior_n = 1'b1; iow_n = 1'b1;
      repeat (6) @(posedge clk); #1;
      check("R7 single-clock overlap", mode, 2'b00);
   endtask

   task automatic t_card();
      logic [4:0] g; logic [3:0] o;
      @(negedge clk); card_sel = 1'b1;
      repeat (2) @(posedge clk); #1;
      check("R5 card mode", mode, 2'b01);
      do_cycle(1'b0, 16'hFFF3, 1'b1, g, o);
      check("R5 card read ignores address", g[4:1], 4'b1100);
      check("R5 card offset", o, 4'h3);
      @(negedge clk); mwe_n = 1'b0; cfg_flash_en = 1'b1; #1;
      check("R6 flash enabled", flash_we_n, 1'b0);
      cfg_flash_en = 1'b0; #1;
      check("R6 flash cfg off", flash_we_n, 1'b1);
      @(negedge clk); mwe_n = 1'b1; cfg_flash_en = 1'b1; aen = 1'b1;
      ior_n = 1'b0; iow_n = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk); ior_n = 1'b1; iow_n = 1'b1;
      repeat (3) @(posedge clk); #1;
      check("R7 no detect in card", mode, 2'b01);
      @(negedge clk); card_sel = 1'b0;
      repeat (2) @(posedge clk); #1;
      check("R5 back to local", mode, 2'b00);
      @(negedge clk); mwe_n = 1'b0; #1;
      check("R6 flash local", flash_we_n, 1'b1);
      mwe_n = 1'b1; cfg_flash_en = 1'b0;
   endtask

   task automatic t_m68();
      logic [4:0] g; logic [3:0] o;
      @(negedge clk); aen = 1'b1; ior_n = 1'b0; iow_n = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk); ior_n = 1'b1; iow_n = 1'b1;
      repeat (3) @(posedge clk); #1;
      check("R7 detect", mode, 2'b10);
      @(negedge clk); card_sel = 1'b1;
      repeat (3) @(posedge clk); #1;
      check("R9 card_sel ignored", mode, 2'b10);
      do_cycle(1'b0, 16'h0302, 1'b0, g, o);
      check("R8 pending read", g[4:1], 4'b0001);
      #1; check("R8 still pending", mode, 2'b10);
      do_cycle(1'b1, 16'h0304, 1'b0, g, o);
      check("R8 confirm write", g[4:1], 4'b1010);
      #1; check("R8 confirmed", mode, 2'b11);
      @(negedge clk); bus16 = 1'b0; addr = 16'h0306; aen = 1'b0; #1;
      check("R10 ack forced", ack16_n, 1'b0);
      do_cycle(1'b0, 16'h0306, 1'b1, g, o);
      check("R10 aen blocks", g[4:1], 4'b0000);
      do_cycle(1'b0, 16'h0706, 1'b0, g, o);
      check("R10 base compared", g[4:1], 4'b0000);
      do_cycle(1'b0, 16'h0309, 1'b0, g, o);
      check("R10 read forwarded", g[4:1], 4'b1100);
      check("R10 offset", o, 4'h9);
      bus16 = 1'b1;
      do_reset();
      #1; check("R9 reset clears", mode, 2'b00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_local();
      t_nomatch();
      t_ack();
      t_short_overlap();
      t_card();
      t_m68();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule